// File: doc/BRIEF.md
# Coprocessor Periodic Wakeup Sequencer

This block decides when a small low-power coprocessor is allowed to run. While armed it counts ticks of a slow clock. When the count reaches the period chosen from a bank of five period registers, it powers the core up and starts it at a stored entry address. It then waits for the core to report a halt or an illegal instruction. At that point it powers the core down and starts a fresh counting interval.

The host writes the period registers. It arms the sequence with a start command that also loads the entry address, and it can clear the enable to stop further wakeups. The coprocessor program can pick which period register governs later intervals with a two-cycle select command. The program can also clear the enable itself. While the system is in deep sleep, a select command is overridden and index 0 is used.

Top module: `wkup_seq`

## Requirements
- R1: Five period registers, indices 0 to 4, are written through `host_per_we_i`/`host_per_idx_i`/`host_per_data_i`. A write with an index above 4 changes none of them. A rewritten value governs the next interval that uses that index.
- R2: A host start pulse accepted while the core is unpowered does four things: it loads the entry address, sets the enable, selects index 0 for the coming interval and restarts the tick count from zero. A start pulse while the core is powered is ignored.
- R3: While counting, each cycle with `tick_i` high adds one tick. On the tick that brings the count to the selected period, `core_pwr_o` rises and `core_start_o` is high for exactly that first powered cycle. A period of 0 behaves as 1. `core_entry_o` holds the loaded entry address and stays stable while the core is powered.
- R4: A halt or illegal-instruction pulse while the core is powered drops `core_pwr_o` at the next clock edge. A new interval then counts from zero.
- R5: A select command with index 0 to 4 becomes the governing index only at the start of the next interval. An interval already in progress keeps its period.
- R6: A select command with an index above 4 is ignored, and the previous selection is kept.
- R7: A select command issued while `deep_sleep_i` is high selects index 0, whatever index it carries.
- R8: A select command takes two cycles. `core_sel_ack_o` is high in the cycle after the command cycle, and the selection is committed at the end of that cycle.
- R9: A host enable clear while counting stops the count at once. No wakeup happens until the next host start.
- R10: An enable clear from the core during a run lets the run continue until its halt. After that no wakeup happens until the next host start.
- R11: `host_running_o` is high exactly while the core is powered and running.
- R12: After reset the core is unpowered, no start or acknowledge is shown, the enable is clear, and index 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One slow-clock tick per high cycle |
| host_start_i | input | 1 | Host start command |
| host_entry_i | input | ADDR_W | Entry address loaded by start |
| host_en_clr_i | input | 1 | Host clears the timer enable |
| host_per_we_i | input | 1 | Period register write strobe |
| host_per_idx_i | input | SEL_W | Period register index to write |
| host_per_data_i | input | PERIOD_W | Period value in ticks |
| deep_sleep_i | input | 1 | System is in deep sleep |
| core_sel_i | input | 1 | Core select command |
| core_sel_idx_i | input | SEL_W | Period index carried by the select |
| core_sel_ack_o | output | 1 | Second (completing) cycle of a select |
| core_en_clr_i | input | 1 | Core clears the timer enable |
| core_halt_i | input | 1 | Core reports a halt |
| core_illegal_i | input | 1 | Core reports an illegal instruction |
| core_pwr_o | output | 1 | Core power-up request |
| core_start_o | output | 1 | One-cycle start strobe to the core |
| core_entry_o | output | ADDR_W | Entry address for the core |
| host_running_o | output | 1 | Status: core powered and running |

## Verification
On every cycle, the assertions check these properties: the start strobe is a single cycle and coincides with the rise of power; a halt or illegal report powers the core down on the next edge; a select is acknowledged one cycle later; a host enable clear outside a run keeps power off; and the entry address stays stable during a run. Only the bench scenarios can show the interval lengths measured in ticks. These show which period register governs each interval, that a selection waits for the next interval, the deep-sleep override and the ignored out-of-range index. They also show that rewritten periods take effect and that a run continues after the core clears the enable.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_COUNT = 2'd1,
      WK_RUN   = 2'd2
   } wk_state_e;
endpackage

// File: rtl/wkup_period_bank.sv
module wkup_period_bank #(
   parameter int          NUM      = 5,
   parameter int          PW       = 16,
   parameter int          SW       = 3,
   parameter logic [PW-1:0] RST_VAL = PW'(1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [SW-1:0] widx_i,
   input  logic [PW-1:0] wdata_i,
   input  logic [SW-1:0] ridx_i,
   output logic [PW-1:0] rdata_o
);
   logic [NUM-1:0][PW-1:0] bank;

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic [PW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= RST_VAL;
         else if (we_i && (widx_i == SW'(g)))   q <= wdata_i;
      end
      assign bank[g] = q;
   end

   always_comb begin
      rdata_o = '0;
      for (int k = 0; k < NUM; k++) begin
         if (ridx_i == SW'(k)) rdata_o = bank[k];
      end
   end
endmodule

// File: rtl/wkup_sel_unit.sv
module wkup_sel_unit #(
   parameter int NUM = 5,
   parameter int SW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          cmd_i,
   input  logic [SW-1:0] idx_i,
   input  logic          low_pwr_i,
   output logic          ack_o,
   output logic [SW-1:0] pend_nxt_o
);
   localparam logic [SW-1:0] LAST_IDX = SW'(NUM - 1);

   logic          s1_vld, s1_upd;
   logic [SW-1:0] s1_idx, pend_q;

   always_comb begin
      pend_nxt_o = pend_q;
      if (flush_i)                 pend_nxt_o = '0;
      else if (s1_vld && s1_upd)   pend_nxt_o = s1_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_upd <= 1'b0;
         s1_idx <= '0;
         pend_q <= '0;
      end else begin
         pend_q <= pend_nxt_o;
         s1_vld <= cmd_i && !flush_i;
         s1_upd <= low_pwr_i || (idx_i <= LAST_IDX);
         s1_idx <= low_pwr_i ? '0 : idx_i;
      end
   end

   assign ack_o = s1_vld;
endmodule

// File: rtl/wkup_tick_timer.sv
module wkup_tick_timer #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          cnt_en_i,
   input  logic [PW-1:0] period_i,
   output logic          hit_o
);
   logic [PW-1:0] cnt_q;
   logic [PW:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + (PW+1)'(1);
   assign hit_o   = cnt_en_i && (cnt_inc >= {1'b0, period_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr_i || hit_o) cnt_q <= '0;
      else if (cnt_en_i)       cnt_q <= cnt_inc[PW-1:0];
   end
endmodule

// File: rtl/wkup_seq.sv
module wkup_seq
   import wkup_pkg::*;
#(
   parameter int NUM_PERIODS = 5,
   parameter int SEL_W       = 3,
   parameter int PERIOD_W    = 16,
   parameter int ADDR_W      = 11,
   parameter int PERIOD_RST  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                host_start_i,
   input  logic [ADDR_W-1:0]   host_entry_i,
   input  logic                host_en_clr_i,
   input  logic                host_per_we_i,
   input  logic [SEL_W-1:0]    host_per_idx_i,
   input  logic [PERIOD_W-1:0] host_per_data_i,
   input  logic                deep_sleep_i,
   input  logic                core_sel_i,
   input  logic [SEL_W-1:0]    core_sel_idx_i,
   output logic                core_sel_ack_o,
   input  logic                core_en_clr_i,
   input  logic                core_halt_i,
   input  logic                core_illegal_i,
   output logic                core_pwr_o,
   output logic                core_start_o,
   output logic [ADDR_W-1:0]   core_entry_o,
   output logic                host_running_o
);
   localparam logic [PERIOD_W-1:0] RST_P = PERIOD_W'(PERIOD_RST);

   if (NUM_PERIODS < 2 || NUM_PERIODS > (1 << SEL_W)) begin : g_bad_num
      $error("wkup_seq: NUM_PERIODS must fit in SEL_W bits and be at least 2");
   end
   if (PERIOD_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("wkup_seq: widths must be positive");
   end

   wk_state_e           state_q;
   logic                en_q, start_q;
   logic [ADDR_W-1:0]   entry_q;
   logic [SEL_W-1:0]    active_q, pend_nxt;
   logic [PERIOD_W-1:0] cur_period;
   logic                start_acc, clr_any, done_evt, hit, counting;

   assign start_acc = host_start_i && (state_q != WK_RUN);
   assign clr_any   = host_en_clr_i || core_en_clr_i;
   assign done_evt  = core_halt_i || core_illegal_i;
   assign counting  = (state_q == WK_COUNT) && !clr_any && !start_acc;

   wkup_period_bank #(
      .NUM(NUM_PERIODS), .PW(PERIOD_W), .SW(SEL_W), .RST_VAL(RST_P)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we_i(host_per_we_i), .widx_i(host_per_idx_i), .wdata_i(host_per_data_i),
      .ridx_i(active_q), .rdata_o(cur_period)
   );

   wkup_sel_unit #(.NUM(NUM_PERIODS), .SW(SEL_W)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .flush_i(start_acc), .cmd_i(core_sel_i), .idx_i(core_sel_idx_i),
      .low_pwr_i(deep_sleep_i), .ack_o(core_sel_ack_o), .pend_nxt_o(pend_nxt)
   );

   wkup_tick_timer #(.PW(PERIOD_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clr_i(state_q != WK_COUNT || start_acc),
      .cnt_en_i(counting && tick_i),
      .period_i(cur_period), .hit_o(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WK_IDLE;
         en_q     <= 1'b0;
         start_q  <= 1'b0;
         entry_q  <= '0;
         active_q <= '0;
      end else if (start_acc) begin
         state_q  <= WK_COUNT;
         en_q     <= 1'b1;
         start_q  <= 1'b0;
         entry_q  <= host_entry_i;
         active_q <= '0;
      end else begin
         if (clr_any) en_q <= 1'b0;
         start_q <= 1'b0;
         unique case (state_q)
            WK_COUNT: begin
               if (clr_any) state_q <= WK_IDLE;
               else if (hit) begin
                  state_q <= WK_RUN;
                  start_q <= 1'b1;
               end
            end
            WK_RUN: begin
               if (done_evt) begin
                  state_q  <= (en_q && !clr_any) ? WK_COUNT : WK_IDLE;
                  active_q <= pend_nxt;
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign core_pwr_o     = (state_q == WK_RUN);
   assign host_running_o = (state_q == WK_RUN);
   assign core_start_o   = start_q;
   assign core_entry_o   = entry_q;
endmodule

// File: rtl/wkup_seq_chk.sv
module wkup_seq_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_start_i,
   input logic              host_en_clr_i,
   input logic              core_sel_i,
   input logic              core_sel_ack_o,
   input logic              core_halt_i,
   input logic              core_illegal_i,
   input logic              core_pwr_o,
   input logic              core_start_o,
   input logic [ADDR_W-1:0] core_entry_o,
   input logic              host_running_o
);
   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |=> !core_start_o);

   p_start_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_pwr_o) |-> core_start_o);

   p_entry_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pwr_o && $past(core_pwr_o)) |-> $stable(core_entry_o));

   p_halt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (core_pwr_o && (core_halt_i || core_illegal_i)) |=> !core_pwr_o);

   p_sel_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_sel_i && !host_start_i) |=> core_sel_ack_o);

   p_host_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en_clr_i && !core_pwr_o && !host_start_i) |=> !core_pwr_o);

   p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_running_o == core_pwr_o);
endmodule

bind wkup_seq wkup_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_start_i(host_start_i),
   .host_en_clr_i(host_en_clr_i), .core_sel_i(core_sel_i),
   .core_sel_ack_o(core_sel_ack_o), .core_halt_i(core_halt_i),
   .core_illegal_i(core_illegal_i), .core_pwr_o(core_pwr_o),
   .core_start_o(core_start_o), .core_entry_o(core_entry_o),
   .host_running_o(host_running_o)
);

// File: tb/wkup_seq_tb.sv
module wkup_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;
   localparam int PW = 16;
   localparam int SW = 3;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          tick_i = 1'b0, host_start_i = 1'b0, host_en_clr_i = 1'b0;
   logic [AW-1:0] host_entry_i = '0;
   logic          host_per_we_i = 1'b0;
   logic [SW-1:0] host_per_idx_i = '0;
   logic [PW-1:0] host_per_data_i = '0;
   logic          deep_sleep_i = 1'b0, core_sel_i = 1'b0;
   logic [SW-1:0] core_sel_idx_i = '0;
   logic          core_en_clr_i = 1'b0, core_halt_i = 1'b0, core_illegal_i = 1'b0;
   logic          core_sel_ack_o, core_pwr_o, core_start_o, host_running_o;
   logic [AW-1:0] core_entry_o;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   int exp_q[$];
   int tcnt = 0, phase = 0;
   logic pwr_q = 1'b0;
   logic [AW-1:0] exp_entry = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wkup_seq #(.PERIOD_W(PW), .ADDR_W(AW), .SEL_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .host_start_i(host_start_i), .host_entry_i(host_entry_i),
      .host_en_clr_i(host_en_clr_i), .host_per_we_i(host_per_we_i),
      .host_per_idx_i(host_per_idx_i), .host_per_data_i(host_per_data_i),
      .deep_sleep_i(deep_sleep_i), .core_sel_i(core_sel_i),
      .core_sel_idx_i(core_sel_idx_i), .core_sel_ack_o(core_sel_ack_o),
      .core_en_clr_i(core_en_clr_i), .core_halt_i(core_halt_i),
      .core_illegal_i(core_illegal_i), .core_pwr_o(core_pwr_o),
      .core_start_o(core_start_o), .core_entry_o(core_entry_o),
      .host_running_o(host_running_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: counts ticks the design could have consumed, pops expected wake intervals.
   always @(negedge clk) begin
      if (rst_n) begin
         if (host_start_i && !pwr_q) tcnt = 0;
         else if (tick_i && !pwr_q) tcnt++;
         if (core_start_o) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected wakeup", tcnt, -1);
            else begin
               int e;
               e = exp_q.pop_front();
               check(tcnt == e, "R3/R5 ticks per interval", tcnt, e);
            end
            check(core_entry_o == exp_entry, "R3 entry address", int'(core_entry_o), int'(exp_entry));
            tcnt = 0;
         end
         pwr_q = core_pwr_o;
         phase++;
         tick_i = (phase % 2 == 0);
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wr_period(input int idx, input int val);
      step();
      host_per_we_i = 1'b1; host_per_idx_i = SW'(idx); host_per_data_i = PW'(val);
      step();
      host_per_we_i = 1'b0;
   endtask

   task automatic host_start(input int entry);
      exp_entry = AW'(entry);
      step();
      host_start_i = 1'b1; host_entry_i = AW'(entry);
      step();
      host_start_i = 1'b0;
   endtask

   task automatic wait_start(input string req);
      int n = 0;
      while (!core_start_o && n < 500) begin step(); n++; end
      check(core_start_o && core_pwr_o, req, int'(core_pwr_o), 1);
   endtask

   task automatic finish_run(input bit illegal, input string req);
      step();
      if (illegal) core_illegal_i = 1'b1; else core_halt_i = 1'b1;
      step();
      core_illegal_i = 1'b0; core_halt_i = 1'b0;
      check(!core_pwr_o && !host_running_o, req, int'(core_pwr_o), 0);
   endtask

   task automatic select(input int idx, input bit ds);
      step();
      core_sel_i = 1'b1; core_sel_idx_i = SW'(idx); deep_sleep_i = ds;
      step();
      core_sel_i = 1'b0; deep_sleep_i = 1'b0;
      check(core_sel_ack_o == 1'b1, "R8 ack in second cycle", int'(core_sel_ack_o), 1);
      step();
      check(core_sel_ack_o == 1'b0, "R8 ack single cycle", int'(core_sel_ack_o), 0);
   endtask

   task automatic quiet(input int n, input string req);
      bit seen = 1'b0;
      for (int i = 0; i < n; i++) begin step(); if (core_pwr_o) seen = 1'b1; end
      check(!seen, req, int'(seen), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check(!core_pwr_o && !core_start_o && !core_sel_ack_o && !host_running_o,
            "R12 reset outputs", int'(core_pwr_o), 0);
      rst_n = 1'b1;
      quiet(10, "R12 no wakeup before start");
      // R1 program periods
      wr_period(0, 3); wr_period(1, 5); wr_period(2, 2); wr_period(3, 7); wr_period(4, 4);
      // R2 start, index 0
      exp_q.push_back(3);
      host_start(12'h123);
      wait_start("R2 first wakeup");
      check(host_running_o, "R11 status while running", int'(host_running_o), 1);
      host_start(12'h055);   // R2 ignored while powered
      exp_entry = 11'h123;
      check(core_entry_o == 11'h123, "R2 start ignored while powered", int'(core_entry_o), 'h123);
      // R5 select 2 during the run
      select(2, 1'b0);
      exp_q.push_back(2);
      finish_run(1'b0, "R4 halt powers down");
      wait_start("R5 wakeup with index 2");
      // R6 invalid index kept at 2
      select(7, 1'b0);
      exp_q.push_back(2);
      finish_run(1'b0, "R4 halt");
      wait_start("R6 index kept");
      // R7 deep sleep select 3 becomes 0
      select(3, 1'b1);
      exp_q.push_back(3);
      finish_run(1'b0, "R4 halt");
      // R5 selection made during counting waits for the next interval
      select(4, 1'b0);
      wait_start("R7 deep sleep forces index 0");
      exp_q.push_back(4);
      finish_run(1'b0, "R4 halt");
      wait_start("R5 deferred index 4");
      // R1 rewrite of period 4, ignored write to index 5
      wr_period(4, 6);
      wr_period(5, 20);
      exp_q.push_back(6);
      finish_run(1'b1, "R4 illegal powers down");
      wait_start("R1 rewritten period");
      finish_run(1'b0, "R4 halt");
      // R9 host clear while counting
      step(); host_en_clr_i = 1'b1; step(); host_en_clr_i = 1'b0;
      quiet(40, "R9 no wakeup after host clear");
      check(exp_q.size() == 0, "R9 no pending wakeups", exp_q.size(), 0);
      // R2 restart selects index 0 again; R1 index 5 write left period 0 at 3
      exp_q.push_back(3);
      host_start(12'h2AA);
      wait_start("R2 restart uses index 0");
      // R10 core clears enable during run
      step(); core_en_clr_i = 1'b1; step(); core_en_clr_i = 1'b0;
      repeat (5) step();
      check(core_pwr_o && host_running_o, "R10 run continues after core clear", int'(core_pwr_o), 1);
      finish_run(1'b0, "R10 halt after core clear");
      quiet(40, "R10 no wakeup after core clear");
      check(exp_q.size() == 0, "R3 all expected wakeups seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule